// File: doc/BRIEF.md
# MDIO Management Transaction Engine

This block runs one read or one write at a time on a two-wire PHY management bus. Software sets up the transaction through four small registers: the PHY address, the register address inside the PHY, and, for a write, the 16-bit payload. It then sets a command bit in the control register. The engine latches the whole frame at that moment. It clocks the frame out on the management clock, which it derives from the system clock, and it releases the data pin whenever the PHY is meant to drive it.

The command bit reads back as set for as long as the frame is on the wire, and it drops by itself when the frame is complete. Software polls that bit. After a read, the data register holds the 16 bits returned by the PHY once the bit has dropped. The PHY configuration register is eight bits wide. Only its low five bits are the PHY address; the upper three bits belong to unrelated controls and are stored untouched.

Top module: `mdio_cmd_engine`

## Requirements
- R1: Register select 1 is an 8-bit PHY configuration register that reads back all eight bits. Only bits [4:0] form the PHY address. Select 2 holds a 5-bit register address, with bits [15:5] reading zero. Select 3 is a 16-bit data register.
- R2: Select 0 is the control register. Writing it with bit 5 set and bit 6 clear while idle starts a write frame. Bit 5 then reads back as 1 until the frame completes, after which the register reads 0.
- R3: Writing the control register with bit 6 set while idle starts a read frame, whether or not bit 5 is also set. During a read, only bit 6 reads back as set.
- R4: A frame is 64 bits, sent MSB first: 32 ones, start bits 01, opcode 10 for a read or 01 for a write, the 5-bit PHY address, the 5-bit register address, turnaround 10, then 16 data bits taken from the data register for a write.
- R5: The management clock idles low. Each of its half periods lasts MDC_HALF system clocks, and a frame takes exactly 64 management clock periods. The data pin changes only while the management clock is low.
- R6: A write frame drives the data pin for all 64 bits. A read frame drives it for the first 46 bits and releases it for the turnaround and all 16 data bits.
- R7: On a read, the PHY's bit is sampled at each management clock rising edge of the 16 data bits, MSB first. The result lands in the data register at completion.
- R8: Any control register write made while a frame runs is ignored, whether it is a clear, the same command or the other command. The frame on the wire is unaffected.
- R9: While idle, the data pin is released and the management clock is low. A control write with neither bit 5 nor bit 6 set starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 control, 1 PHY config, 2 register address, 3 data |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read data of the selected register, combinational |
| mdc | output | 1 | Management clock to the PHY |
| mdioIn | input | 1 | Data pin as seen from the pad |
| mdioOut | output | 1 | Value driven onto the data pin |
| mdioOe | output | 1 | Output enable of the data pin |

## Verification
A bit counter that slips shows up within one management clock period. The frame grows or shrinks, or the turnaround release lands on the wrong bit, and the bench PHY model catches this when it compares the captured 64-bit frame against the expected one. A divider fault changes the measured high time on the very first management clock pulse. A broken command latch shows up in the control readback a cycle after the write: either a command leaks in while busy, or the busy bit fails to drop.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // register select codes
  localparam logic [1:0] SEL_CTRL   = 2'd0;
  localparam logic [1:0] SEL_PHYCFG = 2'd1;
  localparam logic [1:0] SEL_REGADR = 2'd2;
  localparam logic [1:0] SEL_DATA   = 2'd3;

  // control register bit positions
  localparam int CMD_WR_BIT = 5;
  localparam int CMD_RD_BIT = 6;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic shift;   // advance to next frame bit (at MDC fall)
    logic sample;  // capture mdioIn (at MDC rise, read data phase)
    logic done;    // last bit finished
  } seqStrobe_t;
endpackage

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 4,
  parameter int PRE_BITS = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       startRead,
  output logic       busy,
  output logic       mdc,
  output logic       mdioOe,
  output seqStrobe_t stb
);
  localparam int FRAME_BITS = PRE_BITS + 32;
  localparam int BW = $clog2(FRAME_BITS);
  localparam int DW = (MDC_HALF > 2) ? $clog2(MDC_HALF) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
  localparam logic [BW-1:0] TA_FIRST = BW'(PRE_BITS + 14);
  localparam logic [BW-1:0] DATA_FIRST = BW'(PRE_BITS + 16);
  localparam logic [DW-1:0] DIV_LAST = DW'(MDC_HALF - 1);

  logic          running;
  logic          mdcQ;
  logic          rdOp;
  logic [DW-1:0] divCnt;
  logic [BW-1:0] bitIdx;
  logic          edgeNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      mdcQ    <= 1'b0;
      rdOp    <= 1'b0;
      divCnt  <= '0;
      bitIdx  <= '0;
    end else if (!running) begin
      if (start) begin
        running <= 1'b1;
        rdOp    <= startRead;
        divCnt  <= '0;
        bitIdx  <= '0;
        mdcQ    <= 1'b0;
      end
    end else if (divCnt == DIV_LAST) begin
      divCnt <= '0;
      mdcQ   <= ~mdcQ;
      if (mdcQ) begin
        if (bitIdx == LAST_BIT) running <= 1'b0;
        else bitIdx <= bitIdx + 1'b1;
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    edgeNow    = running && (divCnt == DIV_LAST);
    stb.sample = edgeNow && !mdcQ && rdOp && (bitIdx >= DATA_FIRST);
    stb.shift  = edgeNow && mdcQ && (bitIdx != LAST_BIT);
    stb.done   = edgeNow && mdcQ && (bitIdx == LAST_BIT);
  end

  assign busy   = running;
  assign mdc    = mdcQ;
  assign mdioOe = running && !(rdOp && (bitIdx >= TA_FIRST));
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [1:0]  regSel,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  input  logic        busy,
  input  seqStrobe_t  stb,
  input  logic        mdioIn,
  output logic        mdioOut,
  output logic        start,
  output logic        startRead
);
  localparam int FRAME_BITS = PRE_BITS + 32;

  logic [7:0]            phyCfg;
  logic [4:0]            regAdr;
  logic [15:0]           dataReg;
  logic                  cmdRd;
  logic                  cmdWr;
  logic [FRAME_BITS-1:0] frame;
  logic [15:0]           rdShift;
  logic                  ctrlWrite;

  assign ctrlWrite = regWe && (regSel == SEL_CTRL) && !busy;
  assign start     = ctrlWrite && (regWrData[CMD_WR_BIT] || regWrData[CMD_RD_BIT]);
  assign startRead = regWrData[CMD_RD_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phyCfg  <= '0;
      regAdr  <= '0;
      dataReg <= '0;
      cmdRd   <= 1'b0;
      cmdWr   <= 1'b0;
      frame   <= '1;
      rdShift <= '0;
    end else begin
      if (regWe && regSel == SEL_PHYCFG) phyCfg <= regWrData[7:0];
      if (regWe && regSel == SEL_REGADR) regAdr <= regWrData[4:0];
      if (regWe && regSel == SEL_DATA)   dataReg <= regWrData;

      if (ctrlWrite) begin
        cmdRd <= regWrData[CMD_RD_BIT];
        cmdWr <= regWrData[CMD_WR_BIT] && !regWrData[CMD_RD_BIT];
      end

      if (start) begin
        frame <= {{PRE_BITS{1'b1}}, 2'b01,
                  startRead ? 2'b10 : 2'b01,
                  phyCfg[4:0], regAdr, 2'b10, dataReg};
      end else if (stb.shift) begin
        frame <= {frame[FRAME_BITS-2:0], 1'b1};
      end

      if (stb.sample) rdShift <= {rdShift[14:0], mdioIn};

      if (stb.done) begin
        cmdRd <= 1'b0;
        cmdWr <= 1'b0;
        if (cmdRd) dataReg <= rdShift;
      end
    end
  end

  always_comb begin
    unique case (regSel)
      SEL_CTRL:   regRdData = {9'b0, cmdRd, cmdWr, 5'b0};
      SEL_PHYCFG: regRdData = {8'b0, phyCfg};
      SEL_REGADR: regRdData = {11'b0, regAdr};
      default:    regRdData = dataReg;
    endcase
  end

  assign mdioOut = frame[FRAME_BITS-1] | ~busy;
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 4,
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [1:0]  regSel,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  output logic        mdc,
  input  logic        mdioIn,
  output logic        mdioOut,
  output logic        mdioOe
);
  logic       busy;
  logic       start;
  logic       startRead;
  seqStrobe_t stb;

  mdio_seq #(.MDC_HALF(MDC_HALF), .PRE_BITS(PRE_BITS)) uSeq (
    .clk(clk), .rstN(rstN), .start(start), .startRead(startRead),
    .busy(busy), .mdc(mdc), .mdioOe(mdioOe), .stb(stb)
  );

  mdio_dp #(.PRE_BITS(PRE_BITS)) uDp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .busy(busy),
    .stb(stb), .mdioIn(mdioIn), .mdioOut(mdioOut),
    .start(start), .startRead(startRead)
  );
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWe,
  input logic [1:0]  regSel,
  input logic [15:0] regWrData,
  input logic        mdc,
  input logic        mdioOe,
  input logic        busy
);
  // R9: pin released while idle
  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdioOe);
  // R9: management clock low while idle
  a_r9_idle_mdc_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);
  // R2/R3: a frame begins only after a control write carrying a command bit
  a_r2_start_from_cmd: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(regWe && regSel == 2'd0 &&
                          (regWrData[5] || regWrData[6])));
  // R5: management clock only pulses inside a frame
  a_r5_mdc_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> busy);
  // R6: driver turns on only at the start of a frame
  a_r6_oe_on_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdioOe) |-> $rose(busy));
  // R5: frame ends with the clock low
  a_r5_end_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !mdc);
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk uChk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
  .regWrData(regWrData), .mdc(mdc), .mdioOe(mdioOe), .busy(busy)
);

// File: tb/sim_mdio_cmd_engine.sv
module sim_mdio_cmd_engine;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWe;
  logic [1:0]  regSel;
  logic [15:0] regWrData;
  logic [15:0] regRdData;
  logic        mdc;
  logic        mdioIn;
  logic        mdioOut;
  logic        mdioOe;

  always #5 clk = ~clk;

  mdio_cmd_engine #(.MDC_HALF(HALF)) u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioIn(mdioIn), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct {
    bit       isRd;
    bit [4:0] phy;
    bit [4:0] ra;
    bit [15:0] d;
  } txn_t;
  txn_t expQ[$];

  logic [15:0] phyRdVal = 16'h0;
  int frames = 0;

  // ---------------- PHY model / monitor ----------------
  logic        mdcPrev = 1'b0;
  logic        outPrev = 1'b1;
  int          bitCnt = 0;
  logic [63:0] capOut, capOe;
  int          highCnt = 0;
  bit          highBad = 0;
  bit          glitch = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      bitCnt = 0; highCnt = 0; highBad = 0; glitch = 0;
      mdcPrev = 1'b0;
    end else begin
      if (mdc) highCnt++;
      if (mdc && mdcPrev && mdioOut !== outPrev) glitch = 1;
      if (mdc && !mdcPrev) begin
        capOut[63-bitCnt] = mdioOut;
        capOe[63-bitCnt]  = mdioOe;
        if (bitCnt >= 47 && bitCnt <= 62 && capOut[29:28] == 2'b10)
          mdioIn = phyRdVal[15-(bitCnt-47)];
        bitCnt++;
      end
      if (!mdc && mdcPrev) begin
        if (highCnt != HALF) highBad = 1;
        highCnt = 0;
        if (bitCnt == 64) begin
          logic [63:0] e, m;
          txn_t t;
          if (expQ.size() == 0) begin
            check("R4 unexpected frame", 64'd1, 64'd0);
          end else begin
            t = expQ.pop_front();
            e = {32'hFFFF_FFFF, 2'b01, t.isRd ? 2'b10 : 2'b01, t.phy, t.ra, 2'b10, t.d};
            m = t.isRd ? {{46{1'b1}}, 18'b0} : '1;
            check("R4 frame bits", capOut & m, e & m);
            check("R6 drive enable per bit", capOe, m);
            check("R5 MDC half period and MDIO stable while high",
                  {62'd0, highBad, glitch}, 64'd0);
          end
          frames++;
          bitCnt = 0; highBad = 0; glitch = 0;
        end
      end
      mdcPrev = mdc;
      outPrev = mdioOut;
    end
  end

  // ---------------- driver ----------------
  task automatic regWrite(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    regSel = sel; regWrData = val; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [15:0] v);
    @(negedge clk);
    regSel = sel;
    #1 v = regRdData;
  endtask

  task automatic startTxn(input bit isRd, input logic [7:0] cfg, input logic [4:0] ra,
                          input logic [15:0] d, input logic [15:0] cmd);
    txn_t t;
    regWrite(2'd1, {8'h0, cfg});
    regWrite(2'd2, {11'h0, ra});
    if (!isRd) regWrite(2'd3, d);
    t.isRd = isRd; t.phy = cfg[4:0]; t.ra = ra; t.d = d;
    expQ.push_back(t);
    regWrite(2'd0, cmd);
  endtask

  task automatic waitIdle(output int polls);
    logic [15:0] v;
    polls = 0;
    do begin
      regRead(2'd0, v);
      polls++;
    end while (v != 16'h0 && polls < 5000);
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int polls;
    rstN = 1'b0; regWe = 1'b0; regSel = 2'd0; regWrData = '0; mdioIn = 1'b1;
    repeat (3) @(posedge clk);
    regRead(2'd0, v);
    check("R2 control reset value", {48'd0, v}, 64'd0);
    check("R9 idle pins at reset", {62'd0, mdc, mdioOe}, 64'd0);
    @(negedge clk) rstN = 1'b1;

    // R1 register readback
    regWrite(2'd1, 16'h00E5);
    regRead(2'd1, v);  check("R1 phy config readback", {48'd0, v}, 64'h00E5);
    regWrite(2'd2, 16'hFFFA);
    regRead(2'd2, v);  check("R1 register address width", {48'd0, v}, 64'h001A);
    regWrite(2'd3, 16'hBEEF);
    regRead(2'd3, v);  check("R1 data readback", {48'd0, v}, 64'hBEEF);

    // write frame, with ignored commands while busy
    startTxn(0, 8'hE5, 5'h1A, 16'hBEEF, 16'h0020);
    regRead(2'd0, v);  check("R2 write bit set while busy", {48'd0, v}, 64'h0020);
    check("R6 driving during write", {63'd0, mdioOe}, 64'd1);
    regWrite(2'd0, 16'h0040);
    regRead(2'd0, v);  check("R8 read command ignored while busy", {48'd0, v}, 64'h0020);
    regWrite(2'd0, 16'h0000);
    regRead(2'd0, v);  check("R8 clear ignored while busy", {48'd0, v}, 64'h0020);
    waitIdle(polls);
    check("R5 frame length in clocks", {63'd0, (polls >= 490 && polls <= 512)}, 64'd1);
    regRead(2'd0, v);  check("R2 bit self-clears", {48'd0, v}, 64'd0);

    // read frame
    phyRdVal = 16'h1234;
    startTxn(1, 8'h43, 5'h01, 16'h0, 16'h0040);
    regRead(2'd0, v);  check("R3 read bit set while busy", {48'd0, v}, 64'h0040);
    waitIdle(polls);
    regRead(2'd3, v);  check("R7 read data captured", {48'd0, v}, 64'h1234);
    regRead(2'd1, v);  check("R1 upper config bits kept", {48'd0, v}, 64'h0043);

    // both command bits: read wins
    phyRdVal = 16'hA5C3;
    startTxn(1, 8'h1F, 5'h1F, 16'h0, 16'h0060);
    regRead(2'd0, v);  check("R3 both bits run a read", {48'd0, v}, 64'h0040);
    waitIdle(polls);
    regRead(2'd3, v);  check("R7 second read data", {48'd0, v}, 64'hA5C3);

    // control write without command bits
    regWrite(2'd0, 16'hFF9F);
    repeat (20) begin
      @(negedge clk);
      if (mdc || mdioOe) check("R9 no start without command", 64'd1, 64'd0);
    end
    regRead(2'd0, v);  check("R9 control stays clear", {48'd0, v}, 64'd0);
    check("R9 pins idle", {62'd0, mdc, mdioOe}, 64'd0);

    // boundary write frame
    startTxn(0, 8'h1F, 5'h00, 16'h0001, 16'h0020);
    waitIdle(polls);
    repeat (4) @(negedge clk);
    check("R4 all frames seen", frames, 4);
    check("R4 scoreboard drained", expQ.size(), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule